// File: doc/BRIEF.md
# Low-Power Mode Entry Controller

This block decides which low-power state the core moves into when the processor signals a wait-for-interrupt or wait-for-event. Software first programs a small control register with the mode it wants: stop, standby power-down or deep power-down. The processor then raises a one-cycle wait strobe. The controller samples the register contents at that moment and moves to the chosen state. If no mode bit is set, or if a debugger is attached and blocks power-down, the core goes into ordinary sleep instead. A wake event returns the block to the run state.

Entries into the three deeper states are recorded in sticky flags, which software clears by writing ones. When software asks for it, the IO state is frozen on entry to standby and stays frozen after wake-up until software releases it. In sleep and in stop, the flash can be powered off under two separate control bits. When the flash is powered back on, its recovery time is counted in system clocks, and no new wait request is accepted until that count has finished.

Top module: `lpm_entry_ctrl`

## Requirements
- R1: After reset, `lp_state` is 0 (run), `pwr_flags` is 0, `io_hold` is 0, `flash_off` is 0 and `flash_ready` is 1.
- R2: State codes are run=0, sleep=1, stop=2, standby=3, deep=4. Control register address 0 holds stop-enable in bit 0, standby-enable in bit 1 and deep-enable in bit 2. A `wfi_req` pulse in run with the flash ready enters the enabled state on the next cycle, or sleep when no enable bit is set. Writes to addresses 2 and 3 have no effect.
- R3: When several enable bits are set, deep has priority over standby, and standby has priority over stop.
- R4: While `dbg_pd_block` is 1, a wait request always enters sleep, whatever the enable bits are.
- R5: `wake_evt` in any low-power state gives run on the next cycle. Without a wake event the low-power state holds. In run, `wake_evt` has no effect.
- R6: `pwr_flags` bit 0 is set on entry to deep, bit 1 on entry to stop and bit 2 on entry to standby. Writing 1 to a bit at address 1 clears that bit. Writing 0 has no effect. Sleep entry sets no flag.
- R7: If control bit 3 is set when standby is entered, `io_hold` rises and stays high through wake-up. A write to address 0 with bit 6 set clears it, but only while in run. The same write during standby is ignored.
- R8: `flash_off` is 1 in sleep when control bit 4 is set, and 1 in stop when control bit 5 is set. It is 0 in every other case.
- R9: After a wake from a state with the flash off, `flash_ready` stays 0 for exactly WAKE_CYC cycles. A wait request during that time is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register write address |
| bus_wdata | input | DATA_W | Register write data |
| wfi_req | input | 1 | Wait-for-interrupt/event strobe |
| wake_evt | input | 1 | Wake event |
| dbg_pd_block | input | 1 | Debugger power-down inhibit |
| lp_state | output | 3 | Current power state code |
| pwr_flags | output | 3 | Sticky state-visit flags |
| io_hold | output | 1 | IO state frozen |
| flash_off | output | 1 | Flash power-off request |
| flash_ready | output | 1 | Flash powered and recovered |

## Verification
The assertions check, on every cycle, several properties that hold locally. A wake always returns to run. A low-power state holds when there is no wake. The inhibit forces sleep, and deep wins the priority. Flags only fall after a matching write of one. `io_hold` only falls after a release written in run. `flash_ready` drops after a wake with the flash off. Other properties need stimulus from the bench. The bench sweeps every combination of enable bits with and without the inhibit. It checks the exact length of flash recovery for each flash setting, including a wait request that arrives during recovery. It checks that the IO hold survives a release attempted during standby. It also checks that writes of zeros and writes to unused addresses leave the state unchanged.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [2:0] {
        LP_RUN   = 3'd0,
        LP_SLEEP = 3'd1,
        LP_STOP  = 3'd2,
        LP_STBY  = 3'd3,
        LP_DEEP  = 3'd4
    } lp_state_e;

    // control register (address 0) field positions
    localparam int CTL_STOP      = 0;
    localparam int CTL_STBY      = 1;
    localparam int CTL_DEEP      = 2;
    localparam int CTL_HOLD      = 3;
    localparam int CTL_FOFF_SLP  = 4;
    localparam int CTL_FOFF_STOP = 5;
    localparam int CTL_RELEASE   = 6;   // write-only strobe, not stored
    localparam int CTL_W         = 6;

    // flag register (address 1) field positions
    localparam int FLG_DEEP = 0;
    localparam int FLG_STOP = 1;
    localparam int FLG_STBY = 2;
    localparam int FLG_W    = 3;

    localparam int ADDR_CTL = 0;
    localparam int ADDR_FLG = 1;

endpackage

// File: rtl/lpm_regs.sv
module lpm_regs
    import lpm_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [FLG_W-1:0]  set_flags,
    output logic [CTL_W-1:0]  ctrl,
    output logic [FLG_W-1:0]  flags,
    output logic              release_stb
);

    typedef struct packed {
        logic [CTL_W-1:0] ctrl;
        logic [FLG_W-1:0] flags;
    } regs_t;

    regs_t reg_d, reg_q;
    logic  hit_ctl, hit_flg;

    always_comb begin
        hit_ctl = wr_en && (wr_addr == ADDR_W'(ADDR_CTL));
        hit_flg = wr_en && (wr_addr == ADDR_W'(ADDR_FLG));
        reg_d   = reg_q;
        if (hit_ctl) begin
            reg_d.ctrl = wr_data[CTL_W-1:0];
        end
        if (hit_flg) begin
            reg_d.flags = reg_q.flags & ~wr_data[FLG_W-1:0];
        end
        // a new entry outranks a clear in the same cycle
        reg_d.flags = reg_d.flags | set_flags;
        release_stb = hit_ctl && wr_data[CTL_RELEASE];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q <= '0;
        end else begin
            reg_q <= reg_d;
        end
    end

    assign ctrl  = reg_q.ctrl;
    assign flags = reg_q.flags;

    for (genvar gi = 0; gi < FLG_W; gi++) begin : g_flag_chk
        p_flag_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(reg_q.flags[gi]) |->
                $past(wr_en && wr_addr == ADDR_W'(ADDR_FLG) && wr_data[gi]));
        p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
            set_flags[gi] |=> reg_q.flags[gi]);
    end

endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
    import lpm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wfi,
    input  logic             wake,
    input  logic             inhibit,
    input  logic [CTL_W-1:0] ctrl,
    input  logic             flash_ready,
    input  logic             release_stb,
    output lp_state_e        state,
    output logic [FLG_W-1:0] set_flags,
    output logic             io_hold
);

    typedef struct packed {
        lp_state_e st;
        logic      hold;
    } fsm_t;

    fsm_t      fsm_d, fsm_q;
    lp_state_e target;

    always_comb begin
        if (inhibit) begin
            target = LP_SLEEP;
        end else if (ctrl[CTL_DEEP]) begin
            target = LP_DEEP;
        end else if (ctrl[CTL_STBY]) begin
            target = LP_STBY;
        end else if (ctrl[CTL_STOP]) begin
            target = LP_STOP;
        end else begin
            target = LP_SLEEP;
        end
    end

    always_comb begin
        fsm_d     = fsm_q;
        set_flags = '0;
        if (fsm_q.st == LP_RUN) begin
            if (release_stb) begin
                fsm_d.hold = 1'b0;
            end
            if (wfi && flash_ready) begin
                fsm_d.st = target;
                case (target)
                    LP_DEEP: set_flags[FLG_DEEP] = 1'b1;
                    LP_STOP: set_flags[FLG_STOP] = 1'b1;
                    LP_STBY: begin
                        set_flags[FLG_STBY] = 1'b1;
                        if (ctrl[CTL_HOLD]) begin
                            fsm_d.hold = 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end else if (wake) begin
            fsm_d.st = LP_RUN;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q <= '{st: LP_RUN, hold: 1'b0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign state   = fsm_q.st;
    assign io_hold = fsm_q.hold;

    p_wake_returns_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st != LP_RUN && wake) |=> fsm_q.st == LP_RUN);
    p_lp_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st != LP_RUN && !wake) |=> $stable(fsm_q.st));
    p_inhibit_sleep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == LP_RUN && wfi && flash_ready && inhibit) |=> fsm_q.st == LP_SLEEP);
    p_deep_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == LP_RUN && wfi && flash_ready && !inhibit && ctrl[CTL_DEEP])
            |=> fsm_q.st == LP_DEEP);
    p_hold_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fsm_q.hold) |-> $past(release_stb && fsm_q.st == LP_RUN));

endmodule

// File: rtl/lpm_flash_rec.sv
module lpm_flash_rec
    import lpm_pkg::*;
#(
    parameter int WAKE_CYC = 2500
) (
    input  logic             clk,
    input  logic             rst_n,
    input  lp_state_e        state,
    input  logic [CTL_W-1:0] ctrl,
    input  logic             wake,
    output logic             flash_off,
    output logic             flash_ready
);

    localparam int CNT_W = $clog2(WAKE_CYC + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } rec_t;

    rec_t rec_d, rec_q;

    always_comb begin
        flash_off = ((state == LP_SLEEP) && ctrl[CTL_FOFF_SLP]) ||
                    ((state == LP_STOP)  && ctrl[CTL_FOFF_STOP]);
        rec_d = rec_q;
        if (flash_off && wake) begin
            rec_d.cnt = CNT_W'(WAKE_CYC);
        end else if (rec_q.cnt != '0) begin
            rec_d.cnt = rec_q.cnt - 1'b1;
        end
        flash_ready = !flash_off && (rec_q.cnt == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rec_q <= '0;
        end else begin
            rec_q <= rec_d;
        end
    end

    p_recovery_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_off && wake) |=> !flash_ready);

endmodule

// File: rtl/lpm_entry_ctrl.sv
module lpm_entry_ctrl
    import lpm_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 2,
    parameter int WAKE_CYC = 2500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              wfi_req,
    input  logic              wake_evt,
    input  logic              dbg_pd_block,
    output logic [2:0]        lp_state,
    output logic [2:0]        pwr_flags,
    output logic              io_hold,
    output logic              flash_off,
    output logic              flash_ready
);

    logic [CTL_W-1:0] ctrl;
    logic [FLG_W-1:0] flags;
    logic [FLG_W-1:0] set_flags;
    logic             release_stb;
    lp_state_e        state;

    lpm_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) regs_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (bus_wr_en),
        .wr_addr     (bus_addr),
        .wr_data     (bus_wdata),
        .set_flags   (set_flags),
        .ctrl        (ctrl),
        .flags       (flags),
        .release_stb (release_stb)
    );

    lpm_fsm fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wfi         (wfi_req),
        .wake        (wake_evt),
        .inhibit     (dbg_pd_block),
        .ctrl        (ctrl),
        .flash_ready (flash_ready),
        .release_stb (release_stb),
        .state       (state),
        .set_flags   (set_flags),
        .io_hold     (io_hold)
    );

    lpm_flash_rec #(.WAKE_CYC(WAKE_CYC)) flash_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .state       (state),
        .ctrl        (ctrl),
        .wake        (wake_evt),
        .flash_off   (flash_off),
        .flash_ready (flash_ready)
    );

    assign lp_state  = state;
    assign pwr_flags = flags;

    p_flash_on_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LP_RUN || state == LP_STBY || state == LP_DEEP) |-> !flash_off);

endmodule

// File: tb/lpm_entry_ctrl_tb.sv
module lpm_entry_ctrl_tb_top;

    localparam int WCYC = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr_en = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       wfi_req = 1'b0;
    logic       wake_evt = 1'b0;
    logic       dbg_pd_block = 1'b0;
    logic [2:0] lp_state;
    logic [2:0] pwr_flags;
    logic       io_hold;
    logic       flash_off;
    logic       flash_ready;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    lpm_entry_ctrl #(.DATA_W(8), .ADDR_W(2), .WAKE_CYC(WCYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .wfi_req(wfi_req), .wake_evt(wake_evt),
        .dbg_pd_block(dbg_pd_block), .lp_state(lp_state), .pwr_flags(pwr_flags),
        .io_hold(io_hold), .flash_off(flash_off), .flash_ready(flash_ready)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        bus_wr_en = 1'b1; bus_addr = 2'(a); bus_wdata = 8'(d);
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic wfi_pulse();
        wfi_req = 1'b1;
        @(negedge clk);
        wfi_req = 1'b0;
    endtask

    task automatic wake_pulse();
        wake_evt = 1'b1;
        @(negedge clk);
        wake_evt = 1'b0;
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    function automatic int pick(input int m, input int inh);
        if (inh != 0) return 1;
        if (m[2]) return 4;
        if (m[1]) return 3;
        if (m[0]) return 2;
        return 1;
    endfunction

    function automatic int flag_of(input int s);
        return (s == 4) ? 1 : (s == 2) ? 2 : (s == 3) ? 4 : 0;
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 state", lp_state, 0);
        chk("R1 flags", pwr_flags, 0);
        chk("R1 hold", io_hold, 0);
        chk("R1 foff", flash_off, 0);
        chk("R1 ready", flash_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R4 R5 R6: all enable combinations, inhibit on and off
        for (int inh = 0; inh < 2; inh++) begin
            for (int m = 0; m < 8; m++) begin
                int exp_s;
                exp_s = pick(m, inh);
                wr(0, m);
                dbg_pd_block = inh[0];
                chk("R2 R3 run before wfi", lp_state, 0);
                wfi_pulse();
                dbg_pd_block = 1'b0;
                chk((inh != 0) ? "R4 inhibit state" : "R3 entry state", lp_state, exp_s);
                repeat (2) @(negedge clk);
                chk("R5 state holds", lp_state, exp_s);
                chk("R6 flag set", pwr_flags, flag_of(exp_s));
                wr(1, 0);
                chk("R6 write zero", pwr_flags, flag_of(exp_s));
                wake_pulse();
                chk("R5 wake to run", lp_state, 0);
                wr(1, 7);
                chk("R6 clear", pwr_flags, 0);
            end
        end

        // R6: clear one bit of several
        wr(0, 4); wfi_pulse(); wake_pulse();
        wr(0, 1); wfi_pulse(); wake_pulse();
        chk("R6 two flags", pwr_flags, 3);
        wr(1, 2);
        chk("R6 clear bit1 only", pwr_flags, 1);
        wr(1, 7);

        // R5: wake in run ignored; R2: unused address ignored
        wake_pulse();
        chk("R5 wake in run", lp_state, 0);
        wr(0, 0);
        wr(2, 8'hFF);
        wr(3, 8'hFF);
        wfi_pulse();
        chk("R2 unused addr ignored", lp_state, 1);
        wake_pulse();

        // R7: IO hold across standby
        wr(0, 8'h0A);
        wfi_pulse();
        chk("R7 standby", lp_state, 3);
        chk("R7 hold set", io_hold, 1);
        wr(0, 8'h4A);
        chk("R7 release in standby ignored", io_hold, 1);
        wake_pulse();
        chk("R7 hold after wake", io_hold, 1);
        wr(0, 8'h40);
        chk("R7 release", io_hold, 0);
        wr(0, 8'h02);
        wfi_pulse();
        chk("R7 no hold request", io_hold, 0);
        wake_pulse();
        wr(1, 7);

        // R8 R9: flash control sweep, sleep and stop
        for (int fb = 0; fb < 4; fb++) begin
            for (int st = 0; st < 2; st++) begin
                int exp_off;
                int lowc;
                exp_off = (st == 0) ? fb[0] : fb[1];
                wr(0, (fb << 4) | st);
                chk("R8 flash on in run", flash_off, 0);
                wfi_pulse();
                chk("R8 state", lp_state, (st == 0) ? 1 : 2);
                chk("R8 flash off", flash_off, exp_off);
                chk("R8 ready while off", flash_ready, (exp_off != 0) ? 0 : 1);
                wake_pulse();
                lowc = 0;
                for (int k = 0; k < 4 * WCYC; k++) begin
                    if (flash_ready) break;
                    if (lowc == 0) begin
                        wr(0, 0);
                        wfi_req = 1'b1;
                        #0;
                    end
                    lowc++;
                    if (wfi_req) begin
                        @(negedge clk);
                        wfi_req = 1'b0;
                        chk("R9 wfi ignored in recovery", lp_state, 0);
                        lowc++;
                    end else begin
                        @(negedge clk);
                    end
                end
                chk("R9 recovery length", lowc, (exp_off != 0) ? WCYC : 0);
                wr(1, 7);
            end
        end

        report();
    end

endmodule